// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a processor's virtual address into a physical one by consulting a single page table held in main memory. The virtual address is split into a page index and an in-page offset. The block adds the scaled index to a programmable table base to locate the entry, and fetches that entry over a simple memory read port. It then tests the entry's presence flag.

When the page is resident, the block joins the entry's frame number with the offset, reads the data word at that physical address, and stores it in an internal data buffer. It then pulses a completion strobe. When the page is absent, it does not read data. Instead it pulses a fault strobe and presents the faulting virtual address, so that software can bring the page in from secondary storage. Every translation costs exactly one entry read followed by at most one data read. Only one translation is in flight at a time.

Top module: `page_walker`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, while `mem_req_valid`, `resp_valid` and `fault_valid` are 0. `resp_data` is 0 and the table base is 0.
- R2: The first memory read of a translation goes to address base + (vaddr[31:12] << 2), so entries are 32-bit words.
- R3: The table base takes `base_wr_data` on a cycle with `base_wr_en` high and `req_ready` high. A write on a cycle with `req_ready` low is ignored, and later translations still use the old base.
- R4: Bit 31 of an entry is the presence flag and bits 19:0 are the frame number. When bit 31 is 1, the second read goes to {entry[19:0], vaddr[11:0]}. Entry bits 30:20 have no effect.
- R5: On a hit, `resp_valid` is high for exactly one cycle with `resp_data` equal to the word returned by the data read. `resp_data` keeps that value until the next hit completes.
- R6: On a miss (bit 31 = 0), `fault_valid` is high for exactly one cycle with `fault_vaddr` equal to the request's virtual address. No data read is issued, and the frame number is ignored.
- R7: `req_ready` is high only while no translation is in progress, and a request is taken only on a cycle with `req_valid` and `req_ready` both high. A `req_valid` held high during a translation is taken only after that translation ends.
- R8: Once `mem_req_valid` is high, it stays high with an unchanged `mem_req_addr` until a cycle where `mem_req_ready` is also high.
- R9: Assume a memory that is always ready and returns each response in the cycle after the request. Then a hit's `resp_valid` appears 5 cycles after the cycle in which the request is accepted, and a miss's `fault_valid` appears 3 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the table base |
| base_wr_data | input | 32 | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle pulse: access completed |
| resp_data | output | 32 | Data buffer holding the last fetched word |
| fault_valid | output | 1 | One-cycle pulse: page not present |
| fault_vaddr | output | 32 | Virtual address that faulted |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Memory read address |
| mem_resp_valid | input | 1 | Memory read data strobe |
| mem_resp_data | input | 32 | Memory read data |

## Verification
A corrupted controller state shows up at the ports within a cycle or two. It appears as `req_ready` disagreeing with whether a translation is outstanding, as a second memory read after a miss, or as a pulse that lasts more than one cycle. A wrong latched entry or virtual address shows up on the data read address, or on `fault_vaddr`, at the very next read or strobe. A bad base register appears on the next entry address. With a zero-wait memory, any extra or missing state in the sequence moves the completion strobe off its fixed cycle count.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int PW_VA_W        = 32;
    localparam int PW_PA_W        = 32;
    localparam int PW_DATA_W      = 32;
    localparam int PW_OFF_W       = 12;
    localparam int PW_PFN_W       = 20;
    localparam int PW_PRESENT_BIT = 31;
    localparam int PW_ENTRY_SHIFT = 2;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ENTRY_REQ,
        WS_ENTRY_WAIT,
        WS_DATA_REQ,
        WS_DATA_WAIT,
        WS_DONE,
        WS_FAULT
    } walk_state_t;

endpackage

// File: rtl/pw_base_reg.sv
module pw_base_reg #(
    parameter int PA_W = pw_pkg::PW_PA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            idle,
    output logic [PA_W-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en && idle) begin
            base_q <= wr_data;
        end
    end

    // R3
    base_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idle) |=> $stable(base_q));

endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int VA_W        = pw_pkg::PW_VA_W,
    parameter int PA_W        = pw_pkg::PW_PA_W,
    parameter int OFF_W       = pw_pkg::PW_OFF_W,
    parameter int PFN_W       = pw_pkg::PW_PFN_W,
    parameter int ENTRY_SHIFT = pw_pkg::PW_ENTRY_SHIFT
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PFN_W-1:0] pfn,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-1:0]  data_addr
);

    localparam int IDX_W   = VA_W - OFF_W;
    localparam int PHYS_RW = PFN_W + OFF_W;

    logic [IDX_W-1:0]   idx;
    logic [PHYS_RW-1:0] phys_raw;

    assign idx        = vaddr[VA_W-1:OFF_W];
    assign entry_addr = base + (PA_W'(idx) << ENTRY_SHIFT);
    assign phys_raw   = {pfn, vaddr[OFF_W-1:0]};

    generate
        if (PHYS_RW >= PA_W) begin : g_trunc
            assign data_addr = phys_raw[PA_W-1:0];
        end else begin : g_zext
            assign data_addr = {{(PA_W-PHYS_RW){1'b0}}, phys_raw};
        end
    endgenerate

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_resp_valid,
    input  logic entry_present,
    output logic req_ready,
    output logic mem_req_valid,
    output logic sel_data_addr,
    output logic cap_vaddr,
    output logic cap_entry,
    output logic cap_data,
    output logic done_pulse,
    output logic fault_pulse
);

    walk_state_t st, st_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= WS_IDLE;
        end else begin
            st <= st_n;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            WS_IDLE:       if (req_valid)      st_n = WS_ENTRY_REQ;
            WS_ENTRY_REQ:  if (mem_req_ready)  st_n = WS_ENTRY_WAIT;
            WS_ENTRY_WAIT: if (mem_resp_valid) st_n = entry_present ? WS_DATA_REQ : WS_FAULT;
            WS_DATA_REQ:   if (mem_req_ready)  st_n = WS_DATA_WAIT;
            WS_DATA_WAIT:  if (mem_resp_valid) st_n = WS_DONE;
            WS_DONE:       st_n = WS_IDLE;
            WS_FAULT:      st_n = WS_IDLE;
            default:       st_n = WS_IDLE;
        endcase
    end

    assign req_ready     = (st == WS_IDLE);
    assign cap_vaddr     = req_ready && req_valid;
    assign mem_req_valid = (st == WS_ENTRY_REQ) || (st == WS_DATA_REQ);
    assign sel_data_addr = (st == WS_DATA_REQ);
    assign cap_entry     = (st == WS_ENTRY_WAIT) && mem_resp_valid;
    assign cap_data      = (st == WS_DATA_WAIT) && mem_resp_valid;
    assign done_pulse    = (st == WS_DONE);
    assign fault_pulse   = (st == WS_FAULT);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R6
    fault_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> (!fault_pulse && !mem_req_valid));

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int VA_W        = PW_VA_W,
    parameter int PA_W        = PW_PA_W,
    parameter int DATA_W      = PW_DATA_W,
    parameter int OFF_W       = PW_OFF_W,
    parameter int PFN_W       = PW_PFN_W,
    parameter int PRESENT_BIT = PW_PRESENT_BIT,
    parameter int ENTRY_SHIFT = PW_ENTRY_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr_en,
    input  logic [PA_W-1:0]   base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              fault_valid,
    output logic [VA_W-1:0]   fault_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data
);

    logic              sel_data_addr;
    logic              cap_vaddr;
    logic              cap_entry;
    logic              cap_data;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   entry_addr;
    logic [PA_W-1:0]   data_addr;
    logic [VA_W-1:0]   vaddr_q;
    logic [PFN_W-1:0]  pfn_q;
    logic [DATA_W-1:0] mbr_q;

    pw_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_resp_valid (mem_resp_valid),
        .entry_present  (mem_resp_data[PRESENT_BIT]),
        .req_ready      (req_ready),
        .mem_req_valid  (mem_req_valid),
        .sel_data_addr  (sel_data_addr),
        .cap_vaddr      (cap_vaddr),
        .cap_entry      (cap_entry),
        .cap_data       (cap_data),
        .done_pulse     (resp_valid),
        .fault_pulse    (fault_valid)
    );

    pw_base_reg #(.PA_W(PA_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .idle    (req_ready),
        .base_q  (base_q)
    );

    pw_addr_gen #(
        .VA_W        (VA_W),
        .PA_W        (PA_W),
        .OFF_W       (OFF_W),
        .PFN_W       (PFN_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_agen (
        .base       (base_q),
        .vaddr      (vaddr_q),
        .pfn        (pfn_q),
        .entry_addr (entry_addr),
        .data_addr  (data_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_q <= '0;
            pfn_q   <= '0;
            mbr_q   <= '0;
        end else begin
            if (cap_vaddr) vaddr_q <= req_vaddr;
            if (cap_entry) pfn_q   <= mem_resp_data[PFN_W-1:0];
            if (cap_data)  mbr_q   <= mem_resp_data;
        end
    end

    assign mem_req_addr = sel_data_addr ? data_addr : entry_addr;
    assign resp_data    = mbr_q;
    assign fault_vaddr  = vaddr_q;

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

    // R5
    mbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> $stable(resp_data));

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> !resp_valid);

endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        base_wr_en;
    logic [31:0] base_wr_data;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;

    always #5 clk = ~clk;

    page_walker u0 (
        .clk            (clk),
        .rst            (rst),
        .base_wr_en     (base_wr_en),
        .base_wr_data   (base_wr_data),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .resp_valid     (resp_valid),
        .resp_data      (resp_data),
        .fault_valid    (fault_valid),
        .fault_vaddr    (fault_vaddr),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    bit          busy = 0;
    logic [31:0] base_m = '0;
    logic [31:0] last_data = '0;
    logic [31:0] pt [logic [31:0]];
    logic [31:0] exp_addr_q [$];
    string       exp_tag_q [$];
    int          exp_kind_q [$];
    logic [31:0] exp_val_q [$];
    int          cyc = 0;
    int          acc_cyc = 0;
    int          mode = 0;
    int          resp_cnt = 0;
    logic [31:0] resp_val = '0;
    bit          stall_prev = 0;
    logic [31:0] stall_addr = '0;

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        if (pt.exists(a)) return pt[a];
        return (a ^ 32'h5A5A_C3C3) + 32'h11;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            mem_resp_valid = 1'b0;
            mem_req_ready  = 1'b0;
            resp_cnt       = 0;
            stall_prev     = 0;
        end else begin
            // R7: ready exactly when no translation is outstanding
            chk(req_ready == !busy, "R7", "req_ready", {31'b0, req_ready}, {31'b0, !busy});

            // R8: stalled request held with same address
            if (stall_prev) begin
                chk(mem_req_valid == 1'b1, "R8", "request dropped while stalled", {31'b0, mem_req_valid}, 32'd1);
                chk(mem_req_addr == stall_addr, "R8", "address changed while stalled", mem_req_addr, stall_addr);
            end

            // outcome strobes
            if (resp_valid && fault_valid) begin
                chk(1'b0, "R6", "fault and completion together", 32'd1, 32'd0);
            end
            if (resp_valid || fault_valid) begin
                if (exp_kind_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected outcome strobe", {31'b0, resp_valid}, 32'd0);
                end else begin
                    int k;
                    logic [31:0] v;
                    k = exp_kind_q.pop_front();
                    v = exp_val_q.pop_front();
                    if (k == 0) begin
                        chk(resp_valid, "R5", "completion expected", {31'b0, resp_valid}, 32'd1);
                        chk(resp_data == v, "R5", "resp_data", resp_data, v);
                        last_data = v;
                    end else begin
                        chk(fault_valid, "R6", "fault expected", {31'b0, fault_valid}, 32'd1);
                        chk(fault_vaddr == v, "R6", "fault_vaddr", fault_vaddr, v);
                    end
                    if (mode == 0) begin
                        chk((cyc - acc_cyc) == ((k == 0) ? 5 : 3), "R9", "latency",
                            32'(cyc - acc_cyc), (k == 0) ? 32'd5 : 32'd3);
                    end
                end
                busy = 0;
            end else begin
                chk(resp_data == last_data, "R5", "resp_data hold", resp_data, last_data);
            end

            // base register model (R3)
            if (base_wr_en && req_ready) base_m = base_wr_data;

            // request acceptance
            if (req_valid && req_ready) begin
                logic [31:0] ea, ent, da;
                busy    = 1;
                acc_cyc = cyc;
                ea  = base_m + {10'b0, req_vaddr[31:12], 2'b00};
                ent = mem_fn(ea);
                exp_addr_q.push_back(ea);
                exp_tag_q.push_back("R2");
                if (ent[31]) begin
                    da = {ent[19:0], req_vaddr[11:0]};
                    exp_addr_q.push_back(da);
                    exp_tag_q.push_back("R4");
                    exp_kind_q.push_back(0);
                    exp_val_q.push_back(mem_fn(da));
                end else begin
                    exp_kind_q.push_back(1);
                    exp_val_q.push_back(req_vaddr);
                end
            end

            // memory responder
            mem_resp_valid = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = resp_val;
                end
            end
            mem_req_ready = (mode == 0) || (cyc % 3 == 0);
            stall_prev = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected memory read", mem_req_addr, 32'd0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_addr_q.pop_front();
                    t = exp_tag_q.pop_front();
                    chk(mem_req_addr == e, t, "memory read address", mem_req_addr, e);
                end
                resp_val = mem_fn(mem_req_addr);
                resp_cnt = (mode == 0) ? 1 : 1 + (cyc % 4);
            end
        end
    end

    task automatic xlate(input logic [31:0] va);
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1'b1;
        req_vaddr = va;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (busy);
    endtask

    task automatic wr_base(input logic [31:0] d);
        @(posedge clk); #1;
        base_wr_en   = 1'b1;
        base_wr_data = d;
        @(posedge clk); #1;
        base_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        base_wr_en = 1'b0;
        base_wr_data = '0;
        req_valid = 1'b0;
        req_vaddr = '0;
        mem_req_ready = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data = '0;

        // page table contents
        pt[32'h0000_000C] = 32'h8000_0ABC;  // base 0, index 3: present
        pt[32'h003F_FFFC] = 32'h8001_2345;  // base 0, index max
        pt[32'h0010_0054] = 32'hFFF0_0005;  // present, junk in 30:20
        pt[32'h0010_0080] = 32'h0000_0777;  // absent, nonzero frame
        pt[32'h0010_0004] = 32'h8000_0042;
        pt[32'h0010_0008] = 32'h0000_0001;
        pt[32'h0020_0004] = 32'h8000_0099;  // would be used if base changed

        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        #1;
        // R1
        chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", {31'b0, resp_valid}, 32'd0);
        chk(fault_valid == 1'b0, "R1", "fault_valid after reset", {31'b0, fault_valid}, 32'd0);
        chk(resp_data == 32'd0, "R1", "resp_data after reset", resp_data, 32'd0);

        // zero-wait memory, reset base (R1, R2, R4, R9)
        mode = 0;
        xlate(32'h0000_3123); wait_idle();
        xlate(32'hFFFF_FFFF); wait_idle();

        // programmed base, junk upper entry bits (R3, R4)
        wr_base(32'h0010_0000);
        xlate(32'h0001_5FFF); wait_idle();

        // miss: no data read, vaddr reported (R6)
        xlate(32'h0002_0010); wait_idle();
        // hit right after a fault
        xlate(32'h0000_1ABC); wait_idle();

        // base write while busy is ignored (R3)
        xlate(32'h0000_2004);
        wr_base(32'h0020_0000);
        wait_idle();
        xlate(32'h0000_1777); wait_idle();

        // request held high across a busy translation (R7)
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_vaddr = 32'h0000_1010;
        @(posedge clk); #1;
        req_vaddr = 32'h0000_2020;
        while (!busy || req_ready) begin @(posedge clk); #1; end
        while (!req_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();

        // stalling memory with variable response delay (R8)
        mode = 1;
        xlate(32'h0000_1234); wait_idle();
        xlate(32'h0002_0FFF); wait_idle();
        xlate(32'h0001_5000); wait_idle();
        xlate(32'h0000_2ABC); wait_idle();
        xlate(32'h0003_0001); wait_idle();
        mode = 0;
        repeat (4) @(posedge clk);

        chk(exp_addr_q.size() == 0, "R6", "memory reads left outstanding", 32'(exp_addr_q.size()), 32'd0);
        chk(exp_kind_q.size() == 0, "R5", "outcomes left outstanding", 32'(exp_kind_q.size()), 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule